// File: doc/BRIEF.md
# Error-Feedback Sigma-Delta Modulator

This block is a digital single-loop delta-sigma modulator that produces the per-reference-cycle control word for the multi-modulus divider of a fractional-N synthesizer. The desired division ratio arrives as an unsigned fixed-point word. Its upper bits are the integer part and its lower bits the fraction. On every enabled reference clock the block adds a second-order shaped copy of its own past truncation residue to this word. It then cuts the sum into two pieces. The upper piece is registered as the divider select. The lower piece becomes the newest truncation residue.

All arithmetic is unsigned. The truncation residue `e` (lower bits of the sum) is the negative of the quantization error, so adding `2·e[n-1] − e[n-2]` is the same as subtracting the filtered quantization error. This gives the divider sequence a noise transfer function of `(1 − z⁻¹)²`. The filtered term can pull the sum down by at most one LSB-field full scale. For that reason the input is kept above a floor, which keeps the sum from going negative. The input is also kept below a ceiling, which keeps the select within its width. Each output value `k` selects the k-th of eight consecutive divider values.

Top module: `sdm_efb_top`

## Requirements
- R1: While `rst_n` is low, `dout` and both residue history registers are zero. After release, the first enabled cycle outputs `din >> 17`, because the history is zero.
- R2: The internal sum is `v = din + 2·e[n-1] − e[n-2]`. Here `e[n-1]` is the residue of the previous enabled cycle and `e[n-2]` the one before it.
- R3: The quantizer is a plain bit split with 17 LSBs. The output code is bits [19:17] of `v`, and the new residue is bits [16:0] of `v`.
- R4: `dout` is registered. A `din` presented with `en` high before a rising edge appears on `dout` right after that edge.
- R5: With `en` low, `din` is ignored. `dout` and the residue history hold, and the sequence resumes as though the idle cycles never occurred.
- R6: For any input with 131071 ≤ `din` ≤ 786433, the sum is never negative and never reaches 2^20. The bit fields above the output code are therefore always zero.
- R7: For a constant input held over N = 65536 enabled cycles, |Σ`dout`·2^17 − N·`din`| < 2^18. The long-run average therefore equals the input.
- R8: An input that is a whole multiple of 2^17 gives a constant `dout` of `din / 2^17`.
- R9: An input of 3.5·2^17 (458752), starting from reset, gives the repeating sequence 3, 4, 4, 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| en | input | 1 | Clock enable; one modulator step per cycle it is high |
| din | input | 20 | Unsigned division ratio, 3 integer bits and 17 fraction bits |
| dout | output | 3 | Divider select, 0 to 7 |

## Verification
The hardest state to reach is the sum sitting at the edge of its legal range. This occurs when the input lies right at the floor or ceiling and the residue history holds its extreme values. Only a particular run of past residues gets there, and no port can load the history. The stimulus holds the bound values for long stretches, and it mixes them with nearby fractions in a stream that an independent step-by-step model follows. Over these runs the history sweeps through its range, and each output is compared exactly. The enable gap test parks the history mid-sequence while `din` is driven to zero, and then checks that the continuation matches the model.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  localparam int SDM_IN_W    = 20;
  localparam int SDM_OUT_W   = 3;
  localparam int SDM_GUARD_W = 2;

  // smallest input that keeps the sum non-negative: the history term can subtract
  // up to one full residue field
  function automatic int unsigned sdm_floor(input int frac_w);
    return (32'd1 << frac_w) - 32'd1;
  endfunction

  // largest input that keeps the code within its field: the history term can add
  // up to two full residue fields
  function automatic int unsigned sdm_ceil(input int in_w, input int frac_w);
    return (32'd1 << in_w) - (32'd1 << (frac_w + 1)) + 32'd1;
  endfunction

endpackage

// File: rtl/sdm_err_filter.sv
module sdm_err_filter #(
  parameter int FRAC_W = 17,
  parameter int ACC_W  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [FRAC_W-1:0] err_in,
  output logic [ACC_W-1:0]  corr,
  output logic [FRAC_W-1:0] hist1,
  output logic [FRAC_W-1:0] hist2
);

  localparam int TAPS  = 2;
  localparam int EXT_W = ACC_W - FRAC_W;

  logic [FRAC_W-1:0] tap_q [TAPS];
  logic [FRAC_W-1:0] tap_d [TAPS];

  genvar k;
  generate
    for (k = 0; k < TAPS; k++) begin : g_tap
      if (k == 0) begin : g_head
        always_comb tap_d[k] = en ? err_in : tap_q[k];
      end else begin : g_tail
        always_comb tap_d[k] = en ? tap_q[k-1] : tap_q[k];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q[k] <= '0;
        else        tap_q[k] <= tap_d[k];
      end
    end
  endgenerate

  logic [ACC_W-1:0] ext1;
  logic [ACC_W-1:0] ext2;

  always_comb begin
    ext1 = {{EXT_W{1'b0}}, tap_q[0]};
    ext2 = {{EXT_W{1'b0}}, tap_q[1]};
    // residue is the negated quantization error, so adding 2e1 - e2 subtracts
    // the filtered error
    corr = (ext1 << 1) - ext2;
  end

  assign hist1 = tap_q[0];
  assign hist2 = tap_q[1];

endmodule

// File: rtl/sdm_quant_split.sv
module sdm_quant_split #(
  parameter int ACC_W  = 25,
  parameter int FRAC_W = 17,
  parameter int OUT_W  = 3
) (
  input  logic [ACC_W-1:0]              sum,
  output logic [OUT_W-1:0]              code,
  output logic [FRAC_W-1:0]             resid,
  output logic [ACC_W-FRAC_W-OUT_W-1:0] guard
);

  localparam int TOP_LO = FRAC_W + OUT_W;

  always_comb begin
    resid = sum[FRAC_W-1:0];
    code  = sum[FRAC_W +: OUT_W];
    guard = sum[ACC_W-1:TOP_LO];
  end

endmodule

// File: rtl/sdm_efb_top.sv
module sdm_efb_top #(
  parameter int W_IN    = sdm_pkg::SDM_IN_W,
  parameter int W_OUT   = sdm_pkg::SDM_OUT_W,
  parameter int GUARD_W = sdm_pkg::SDM_GUARD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [W_IN-1:0]  din,
  output logic [W_OUT-1:0] dout
);

  localparam int FRAC_W = W_IN - W_OUT;
  localparam int ACC_W  = W_IN + W_OUT + GUARD_W;
  localparam int HI_W   = ACC_W - FRAC_W - W_OUT;

  logic [ACC_W-1:0]  corr;
  logic [ACC_W-1:0]  sum;
  logic [W_OUT-1:0]  code;
  logic [FRAC_W-1:0] resid;
  logic [HI_W-1:0]   sum_guard;
  logic [FRAC_W-1:0] hist1;
  logic [FRAC_W-1:0] hist2;
  logic [W_OUT-1:0]  dout_q;
  logic [W_OUT-1:0]  dout_d;

  sdm_err_filter #(
    .FRAC_W (FRAC_W),
    .ACC_W  (ACC_W)
  ) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .err_in (resid),
    .corr   (corr),
    .hist1  (hist1),
    .hist2  (hist2)
  );

  always_comb sum = {{(ACC_W-W_IN){1'b0}}, din} + corr;

  sdm_quant_split #(
    .ACC_W  (ACC_W),
    .FRAC_W (FRAC_W),
    .OUT_W  (W_OUT)
  ) u_split (
    .sum   (sum),
    .code  (code),
    .resid (resid),
    .guard (sum_guard)
  );

  always_comb dout_d = en ? code : dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;

endmodule

// File: rtl/sdm_efb_chk.sv
module sdm_efb_chk #(
  parameter int W_IN    = 20,
  parameter int W_OUT   = 3,
  parameter int GUARD_W = 2
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             en,
  input logic [W_IN-1:0]                  din,
  input logic [W_OUT-1:0]                 dout,
  input logic [GUARD_W+W_IN-W_OUT-W_OUT+W_OUT-W_IN+W_IN-W_IN+W_OUT-1:0] sum_guard,
  input logic [W_IN-W_OUT-1:0]            hist1,
  input logic [W_IN-W_OUT-1:0]            hist2
);

  localparam int FRAC_W = W_IN - W_OUT;
  localparam int unsigned MIN_IN = sdm_pkg::sdm_floor(FRAC_W);
  localparam int unsigned MAX_IN = sdm_pkg::sdm_ceil(W_IN, FRAC_W);
  localparam logic [W_IN-1:0] LO_B = MIN_IN[W_IN-1:0];
  localparam logic [W_IN-1:0] HI_B = MAX_IN[W_IN-1:0];

  // R6: input at or above the floor whenever a step is taken
  p_input_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> din >= LO_B);

  // R6: input at or below the ceiling whenever a step is taken
  p_input_ceil_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> din <= HI_B);

  // R6: sum neither negative nor past the code field
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> sum_guard == '0);

  // R5: idle cycle freezes output and history
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(dout) && $stable(hist1) && $stable(hist2)));

  // R2: older tap takes the previous newer tap on each step
  p_history_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> hist2 == $past(hist1));

  // R1: state is cleared on leaving reset
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dout == '0 && hist1 == '0 && hist2 == '0));

endmodule

bind sdm_efb_top sdm_efb_chk #(
  .W_IN    (W_IN),
  .W_OUT   (W_OUT),
  .GUARD_W (GUARD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .din       (din),
  .dout      (dout),
  .sum_guard (sum_guard),
  .hist1     (hist1),
  .hist2     (hist2)
);

// File: tb/tb_sdm_efb_top.sv
`timescale 1ns/1ps
module tb_sdm_efb_top;

  localparam int FW   = 17;
  localparam int LOIN = (1 << FW) - 1;
  localparam int HIIN = (1 << 20) - (1 << (FW + 1)) + 1;
  localparam int HALF = 458752;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [19:0] din;
  logic [2:0]  dout;

  int total;
  int bad;
  longint m1;
  longint m2;

  sdm_efb_top dut (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .din   (din),
    .dout  (dout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample at following negedge
  task automatic step(input int x, input bit e);
    din = x[19:0];
    en  = e;
    @(posedge clk);
    @(negedge clk);
  endtask

  // independent model of R2/R3, one enabled step
  task automatic model_step(input int x, input string req);
    longint v;
    longint y;
    v = longint'(x) + 2 * m1 - m2;
    y = v >>> FW;
    m2 = m1;
    m1 = v & ((64'd1 << FW) - 1);
    step(x, 1'b1);
    check(req, longint'(dout), y);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en    = 1'b0;
    din   = '0;
    m1 = 0;
    m2 = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    step(HALF, 1'b1);
    step(HALF, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 dout cleared in reset", longint'(dout), 0);
    @(negedge clk);
    rst_n = 1'b1;
    m1 = 0;
    m2 = 0;
    step(HALF, 1'b1);
    check("R1 first output after reset", longint'(dout), 3);
    step(HALF, 1'b1);
    check("R1 second output after reset", longint'(dout), 4);
  endtask

  task automatic t_half();
    int pat[4] = '{3, 4, 4, 3};
    do_reset();
    for (int i = 0; i < 12; i++) begin
      step(HALF, 1'b1);
      check("R9 R4 half-step pattern", longint'(dout), longint'(pat[i % 4]));
    end
  endtask

  task automatic t_integer();
    int vals[3] = '{1, 4, 5};
    for (int j = 0; j < 3; j++) begin
      do_reset();
      for (int i = 0; i < 6; i++) begin
        step(vals[j] << FW, 1'b1);
        check("R8 integer input constant", longint'(dout), longint'(vals[j]));
      end
    end
  endtask

  task automatic t_stream();
    int seq[8] = '{LOIN, HIIN, 300007, LOIN + 1, 655361, HIIN - 3, 200000, 524287};
    do_reset();
    for (int i = 0; i < 400; i++) begin
      int x;
      x = (i % 7 < 3) ? seq[i % 8] : seq[(i * 3) % 8];
      model_step(x, "R2 R3 R6 stream vs model");
    end
    for (int i = 0; i < 40; i++) model_step(LOIN, "R6 floor input");
    for (int i = 0; i < 40; i++) model_step(HIIN, "R6 ceiling input");
  endtask

  task automatic t_enable();
    logic [2:0] held;
    do_reset();
    for (int i = 0; i < 5; i++) model_step(300007, "R5 pre-gap");
    held = dout;
    for (int i = 0; i < 6; i++) begin
      step(0, 1'b0);
      check("R5 dout holds with en low", longint'(dout), longint'(held));
    end
    for (int i = 0; i < 10; i++) model_step(300007, "R5 resume after gap");
  endtask

  task automatic t_average(input int x);
    longint acc;
    longint diff;
    do_reset();
    acc = 0;
    din = x[19:0];
    en  = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      @(posedge clk);
      @(negedge clk);
      acc += longint'(dout);
    end
    en = 1'b0;
    diff = acc * (64'd1 << FW) - 64'd65536 * longint'(x);
    if (diff < 0) diff = -diff;
    check("R7 long-run average", (diff < (64'd1 << (FW + 1))) ? 1 : 0, 1);
  endtask

  initial begin
    total = 0;
    bad   = 0;
    m1 = 0;
    m2 = 0;
    rst_n = 1'b0;
    en    = 1'b0;
    din   = '0;
    @(negedge clk);
    check("R1 dout zero at reset", longint'(dout), 0);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_half();
    t_integer();
    t_stream();
    t_enable();
    t_average(300007);
    t_average(HIIN);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule